// File: doc/BRIEF.md
# Interrupt Line Router for Legacy and Advanced Controllers

This block takes eight level-sensitive shared PCI interrupt lines and one power-management interrupt and drives them onto 24 interrupt-controller pins. Pins 0 to 15 feed a legacy programmable controller and pins 16 to 23 feed an advanced controller. Software programs one route byte per shared line. The byte names the legacy pin for that line or disables legacy routing for it. On the advanced side each shared line always reaches its own fixed pin.

A small control register selects which pin carries the power-management interrupt and gates decoding of the power-management I/O base. When the interrupt is moved while it is asserted, it is dropped for one cycle before it appears on its new pin. Any downstream edge logic therefore sees a clean release and a fresh assertion.

Top module: `pirq_router`

## Requirements
- R1: A byte write at address 0x60+k (k = 0..3) loads the route byte of line k, and a write at 0x68+k loads the route byte of line 4+k. A route byte is laid out as bit 7 = disable (1 means no legacy route) and bits 6:0 = legacy pin number.
- R2: Legacy pin n (0..15) is high when any enabled line whose pin field equals n is high. It is also high when the power-management interrupt is driven and mapped to n. Several sources on one pin combine as a wired OR.
- R3: An enabled route whose pin field is 16 or more drives no legacy pin. A disabled route drives no legacy pin whatever its pin field holds.
- R4: Pin 16+k follows line k in the same cycle, with no dependence on its route byte. It is also ORed with the power-management interrupt when that interrupt is mapped to 16+k.
- R5: The control register sits at address 0x44, with bit 7 = base enable and bits 2:0 = interrupt select. Select codes 0, 1, 2, 4 and 5 move the interrupt to pins 9, 10, 11, 20 and 21. The move takes effect two clock edges after the write edge. Codes 3, 6 and 7 leave the current pin unchanged.
- R6: The power-management interrupt input is registered. Its level shows on exactly one pin, one cycle after it is sampled.
- R7: If the interrupt is asserted when its pin changes, it is absent from both the old and the new pin for one cycle. After that cycle it is asserted on the new pin.
- R8: The base register is written as bytes at 0x40 to 0x43, least significant byte first. The base output is the register ANDed with 0x0000FF80 when the enable bit is set, and zero otherwise.
- R9: After reset every route byte is 0x80, the control register is zero, the base register is 0x00000001, the interrupt level is low and the interrupt pin is 9.
- R10: A write to any route byte raises route_chg for exactly the one cycle after the write edge. Writes to other addresses do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Config byte write enable |
| cfg_addr | input | 8 | Config byte address |
| cfg_wdata | input | 8 | Config write data |
| pirq_in | input | 8 | Shared interrupt line levels A..H |
| sci_in | input | 1 | Power-management interrupt level |
| irq_out | output | 24 | Controller pin levels, 0..15 legacy, 16..23 advanced |
| route_chg | output | 1 | One-cycle strobe after a route write |
| pm_base | output | 32 | Decoded power-management I/O base |

## Verification
The bench builds the block with its default parameters: eight lines, sixteen legacy pins, and route, control and base registers at 0x60/0x68, 0x44 and 0x40. With these values every legal interrupt target is reachable, including both advanced-side targets 20 and 21. The bench exercises pin fields that overflow the legacy range, and a line routed onto the same legacy pin as the power-management interrupt. The move test observes the one-cycle gap on the exact cycles around a retarget.

// File: rtl/pirq_rt_pkg.sv
// Shared types for the interrupt line router.
// Assumes no more than 32 controller pins, so a 5-bit pin index is enough.
package pirq_rt_pkg;

    // One route byte: disable flag above a legacy pin number.
    typedef struct packed {
        logic       dis;
        logic [6:0] pin;
    } route_t;

    // Stored control bits: base enable and interrupt target select.
    typedef struct packed {
        logic       en;
        logic [2:0] sel;
    } acpi_ctl_t;

    // Decoded interrupt target: legal flag and pin index.
    typedef struct packed {
        logic       ok;
        logic [4:0] pin;
    } sci_tgt_t;

    // Maps a select code to its pin; reserved codes return ok = 0.
    function automatic sci_tgt_t sci_decode(input logic [2:0] sel);
        sci_tgt_t t;
        t.ok  = 1'b1;
        t.pin = 5'd9;
        case (sel)
            3'd0:    t.pin = 5'd9;
            3'd1:    t.pin = 5'd10;
            3'd2:    t.pin = 5'd11;
            3'd4:    t.pin = 5'd20;
            3'd5:    t.pin = 5'd21;
            default: t.ok  = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
// Config register file: route bytes, control bits and base register.
// Assumes byte-wide writes and an even line count split into two equal groups.
module pirq_cfg_regs
    import pirq_rt_pkg::*;
#(
    parameter int          N_PIRQ        = 8,
    parameter int          ADDR_W        = 8,
    parameter int          ROUTE_LO_ADDR = 'h60,
    parameter int          ROUTE_HI_ADDR = 'h68,
    parameter int          CTRL_ADDR     = 'h44,
    parameter int          PMB_ADDR      = 'h40,
    parameter logic [7:0]  ROUTE_DEFAULT = 8'h80,
    parameter logic [3:0]  CTRL_DEFAULT  = 4'h0,
    parameter logic [31:0] PMB_DEFAULT   = 32'h0000_0001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output route_t [N_PIRQ-1:0]     routes_o,
    output acpi_ctl_t               ctl_o,
    output logic [31:0]             pmb_o,
    output logic                    route_chg_o
);

    localparam int GRP       = N_PIRQ / 2;
    localparam int PMB_BYTES = 4;

    logic [N_PIRQ-1:0] route_hit;

    // Address of the route byte for line k.
    function automatic logic [ADDR_W-1:0] route_addr(input int k);
        return (k < GRP) ? ADDR_W'(ROUTE_LO_ADDR + k) : ADDR_W'(ROUTE_HI_ADDR + k - GRP);
    endfunction

    // Decode which route byte, if any, the current write targets.
    always_comb begin
        for (int k = 0; k < N_PIRQ; k++) begin
            route_hit[k] = cfg_we && (cfg_addr == route_addr(k));
        end
    end

    // Register updates and the route-change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_PIRQ; k++) routes_o[k] <= route_t'(ROUTE_DEFAULT);
            ctl_o       <= acpi_ctl_t'(CTRL_DEFAULT);
            pmb_o       <= PMB_DEFAULT;
            route_chg_o <= 1'b0;
        end else begin
            route_chg_o <= |route_hit;
            for (int k = 0; k < N_PIRQ; k++) begin
                if (route_hit[k]) routes_o[k] <= route_t'(cfg_wdata);
            end
            if (cfg_we && cfg_addr == ADDR_W'(CTRL_ADDR)) begin
                ctl_o <= '{en: cfg_wdata[7], sel: cfg_wdata[2:0]};
            end
            for (int b = 0; b < PMB_BYTES; b++) begin
                if (cfg_we && cfg_addr == ADDR_W'(PMB_ADDR + b)) pmb_o[8*b +: 8] <= cfg_wdata;
            end
        end
    end

    a_r10_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|route_hit) |=> route_chg_o);
    a_r10_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> !route_chg_o);

endmodule

// File: rtl/pirq_sci_ctl.sv
// Power-management interrupt control: registers the level, tracks the target
// pin and inserts a one-cycle gap when an asserted interrupt is retargeted.
// Assumes the select field is stable in the control register once written.
module pirq_sci_ctl
    import pirq_rt_pkg::*;
#(
    parameter logic [4:0] RESET_PIN = 5'd9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sci_in,
    input  acpi_ctl_t ctl_i,
    output logic [4:0] sci_pin_o,
    output logic      sci_drive_o
);

    sci_tgt_t tgt;
    logic     sci_q;
    logic     hold_q;
    logic     move;

    // Decode the select field and detect a pending retarget.
    always_comb begin
        tgt  = sci_decode(ctl_i.sel);
        move = tgt.ok && (tgt.pin != sci_pin_o);
    end

    // Level register, target pin and retarget gap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_q     <= 1'b0;
            hold_q    <= 1'b0;
            sci_pin_o <= RESET_PIN;
        end else begin
            sci_q  <= sci_in;
            hold_q <= move && sci_q;
            if (move) sci_pin_o <= tgt.pin;
        end
    end

    assign sci_drive_o = sci_q & ~hold_q;

    a_r5_pin_legal: assert property (@(posedge clk) disable iff (!rst_n)
        sci_pin_o inside {5'd9, 5'd10, 5'd11, 5'd20, 5'd21});
    a_r5_reserved_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt.ok |=> $stable(sci_pin_o));
    a_r7_gap_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        (move && sci_q) |=> !sci_drive_o);
    a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_in && !move) |=> sci_drive_o);
    a_r6_low_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !sci_in |=> !sci_drive_o);

endmodule

// File: rtl/pirq_pin_mux.sv
// Combinational OR network from lines and the interrupt onto controller pins.
// Assumes the total pin count fits a 5-bit index.
module pirq_pin_mux
    import pirq_rt_pkg::*;
#(
    parameter int N_PIRQ = 8,
    parameter int N_PIC  = 16,
    localparam int N_OUT = N_PIC + N_PIRQ
) (
    input  route_t [N_PIRQ-1:0] routes_i,
    input  logic [N_PIRQ-1:0]   pirq_i,
    input  logic                sci_drive_i,
    input  logic [4:0]          sci_pin_i,
    output logic [N_OUT-1:0]    irq_o
);

    for (genvar n = 0; n < N_PIC; n++) begin : g_pic
        logic pic_hit;
        // Wired OR of every enabled line programmed to legacy pin n.
        always_comb begin
            pic_hit = sci_drive_i && (sci_pin_i == 5'(n));
            for (int k = 0; k < N_PIRQ; k++) begin
                pic_hit = pic_hit | (!routes_i[k].dis && routes_i[k].pin == 7'(n) && pirq_i[k]);
            end
        end
        assign irq_o[n] = pic_hit;
    end

    for (genvar k = 0; k < N_PIRQ; k++) begin : g_apic
        // Fixed pass-through of line k, plus the interrupt when mapped here.
        assign irq_o[N_PIC+k] = pirq_i[k] | (sci_drive_i && sci_pin_i == 5'(N_PIC + k));
    end

endmodule

// File: rtl/pirq_router.sv
// Top of the interrupt line router: config registers, interrupt control
// and the pin OR network, plus the decoded power-management base.
// Assumes synchronous active-low reset and byte-wide config writes.
module pirq_router
    import pirq_rt_pkg::*;
#(
    parameter int          N_PIRQ   = 8,
    parameter int          N_PIC    = 16,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] PMB_MASK = 32'h0000_FF80,
    localparam int         N_OUT    = N_PIC + N_PIRQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [N_PIRQ-1:0] pirq_in,
    input  logic              sci_in,
    output logic [N_OUT-1:0]  irq_out,
    output logic              route_chg,
    output logic [31:0]       pm_base
);

    route_t [N_PIRQ-1:0] routes;
    acpi_ctl_t           ctl;
    logic [31:0]         pmb;
    logic [4:0]          sci_pin;
    logic                sci_drive;

    pirq_cfg_regs #(.N_PIRQ(N_PIRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .routes_o   (routes),
        .ctl_o      (ctl),
        .pmb_o      (pmb),
        .route_chg_o(route_chg)
    );

    pirq_sci_ctl u_sci (
        .clk        (clk),
        .rst_n      (rst_n),
        .sci_in     (sci_in),
        .ctl_i      (ctl),
        .sci_pin_o  (sci_pin),
        .sci_drive_o(sci_drive)
    );

    pirq_pin_mux #(.N_PIRQ(N_PIRQ), .N_PIC(N_PIC)) u_mux (
        .routes_i   (routes),
        .pirq_i     (pirq_in),
        .sci_drive_i(sci_drive),
        .sci_pin_i  (sci_pin),
        .irq_o      (irq_out)
    );

    // Base is decoded only while enabled, and aligned by the mask.
    always_comb pm_base = ctl.en ? (pmb & PMB_MASK) : 32'h0;

    a_r8_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_base & ~PMB_MASK) == 32'h0);
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'('h44) && !cfg_wdata[7]) |=> (pm_base == 32'h0));
    a_r4_apic_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_in & ~irq_out[N_PIC +: N_PIRQ]) == '0);
    a_r7_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_in == '0) |-> $countones(irq_out) <= 1);

endmodule

// File: tb/pirq_router_test.sv
`timescale 1ns/100ps
module pirq_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h0;
    logic [7:0]  cfg_wdata = 8'h0;
    logic [7:0]  pirq_in = 8'h0;
    logic        sci_in = 1'b0;
    logic [23:0] irq_out;
    logic        route_chg;
    logic [31:0] pm_base;

    int checks = 0;
    int errors = 0;
    logic [7:0] rt_sh [8];

    always #2.5 clk = ~clk;

    pirq_router uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pirq_in(pirq_in), .sci_in(sci_in),
        .irq_out(irq_out), .route_chg(route_chg), .pm_base(pm_base)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Expected pin levels from the requirements and the shadow route bytes.
    function automatic logic [23:0] model(input logic [7:0] p, input logic s_on, input int s_pin);
        logic [23:0] e = '0;
        for (int k = 0; k < 8; k++) begin
            if (!rt_sh[k][7] && rt_sh[k][6:0] < 16 && p[k]) e[rt_sh[k][6:0]] = 1'b1;
            if (p[k]) e[16+k] = 1'b1;
        end
        if (s_on) e[s_pin] = 1'b1;
        return e;
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_route(input int k, input logic [7:0] v);
        rt_sh[k] = v;
        cfg_write((k < 4) ? 8'(8'h60 + k) : 8'(8'h68 + k - 4), v);
    endtask

    task automatic set_pirq(input logic [7:0] p);
        pirq_in = p;
        #1;
    endtask

    task automatic t_reset;
        for (int k = 0; k < 8; k++) rt_sh[k] = 8'h80;
        chk("R9 idle pins", 32'(irq_out), 32'h0);
        chk("R9 base zero", pm_base, 32'h0);
        chk("R9 no strobe", 32'(route_chg), 32'h0);
        set_pirq(8'hFF);
        chk("R9 routes disabled", 32'(irq_out), 32'h00FF0000);
        set_pirq(8'h00);
        sci_in = 1'b1;
        @(negedge clk);
        chk("R9 interrupt on pin 9", 32'(irq_out), 32'h00000200);
        sci_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_pic_or;
        set_route(0, 8'h05);
        set_route(1, 8'h05);
        set_route(2, 8'h0B);
        set_route(3, 8'h0E);
        set_route(4, 8'h03);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] p;
            p = (i == 5) ? 8'h1F : 8'(1 << i);
            set_pirq(p);
            chk($sformatf("R2 pattern %h", p), 32'(irq_out), 32'(model(p, 1'b0, 9)));
        end
        set_pirq(8'h10);
        chk("R1 high-group offset", 32'(irq_out), 32'h00100008);
        set_pirq(8'h00);
    endtask

    task automatic t_disable_high;
        set_route(5, 8'h87);
        set_route(6, 8'h12);
        set_route(7, 8'h50);
        set_pirq(8'h20);
        chk("R3 disabled route", 32'(irq_out), 32'h00200000);
        set_pirq(8'hC0);
        chk("R3 field above 15", 32'(irq_out), 32'h00C00000);
        set_pirq(8'hFF);
        chk("R4 advanced pass-through", 32'(irq_out), 32'(model(8'hFF, 1'b0, 9)));
        set_pirq(8'h00);
    endtask

    task automatic t_sci_select;
        int codes [5] = '{1, 2, 4, 5, 0};
        int pins  [5] = '{10, 11, 20, 21, 9};
        sci_in = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            cfg_write(8'h44, 8'(codes[i]));
            @(negedge clk); @(negedge clk);
            chk($sformatf("R5 code %0d", codes[i]), 32'(irq_out), 32'(model(8'h00, 1'b1, pins[i])));
        end
        for (int r = 0; r < 3; r++) begin
            logic [7:0] c;
            c = (r == 0) ? 8'h03 : (r == 1) ? 8'h06 : 8'h07;
            cfg_write(8'h44, c);
            @(negedge clk); @(negedge clk);
            chk($sformatf("R5 reserved %0d", c), 32'(irq_out), 32'h00200000);
        end
        cfg_write(8'h44, 8'h00);
        @(negedge clk); @(negedge clk);
        chk("R5 code 0", 32'(irq_out), 32'h00000200);
    endtask

    task automatic t_sci_move;
        cfg_write(8'h44, 8'h04);
        chk("R7 old pin before move", 32'(irq_out), 32'h00000200);
        @(negedge clk);
        chk("R7 gap cycle", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R7 new pin", 32'(irq_out), 32'h00100000);
        cfg_write(8'h44, 8'h00);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_sci_level;
        set_route(0, 8'h09);
        set_pirq(8'h01);
        chk("R2 shared pin", 32'(irq_out), 32'h00010200);
        sci_in = 1'b0;
        #1;
        chk("R6 registered level", 32'(irq_out), 32'h00010200);
        set_pirq(8'h00);
        @(negedge clk);
        chk("R6 level dropped", 32'(irq_out), 32'h0);
        set_pirq(8'h01);
        chk("R2 line alone on 9", 32'(irq_out), 32'h00010200);
        set_pirq(8'h00);
    endtask

    task automatic t_pm_base;
        cfg_write(8'h40, 8'h81);
        cfg_write(8'h41, 8'h12);
        cfg_write(8'h42, 8'h34);
        cfg_write(8'h43, 8'h56);
        chk("R8 gated off", pm_base, 32'h0);
        cfg_write(8'h44, 8'h80);
        chk("R8 masked base", pm_base, 32'h00001280);
        cfg_write(8'h44, 8'h00);
        chk("R8 gated again", pm_base, 32'h0);
    endtask

    task automatic t_route_strobe;
        set_route(3, 8'h80);
        chk("R10 strobe high", 32'(route_chg), 32'h1);
        @(negedge clk);
        chk("R10 strobe one cycle", 32'(route_chg), 32'h0);
        cfg_write(8'h44, 8'h00);
        chk("R10 no strobe on control", 32'(route_chg), 32'h0);
        cfg_write(8'h64, 8'h01);
        chk("R10 no strobe on gap address", 32'(route_chg), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pic_or();
        t_disable_high();
        t_sci_select();
        t_sci_move();
        t_sci_level();
        t_pm_base();
        t_route_strobe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule